// File: doc/BRIEF.md
# Dual-Channel CCD Frame Capture Sequencer

This block collects one frame of pixel samples from a linear image sensor that presents its even and odd pixels on two video outputs at the same time. A pixel trigger marks each pixel window. On its rising edge the sequencer asks a shared converter for two conversions in a fixed order: the even channel first, then the odd channel. Each result is written to an external frame buffer as a zero-extended word. The even sample goes to address 2k and the odd sample to address 2k+1, so the two streams end up interleaved.

Capture is not free-running. The sensor's frame-start (shift gate) strobe drives a decimating counter, and only every Nth strobe arms a capture. Once armed, the sequencer takes exactly one frame and then goes idle. A new arm always restarts the capture at address 0, even if a frame is partly taken.

A finished frame goes to a downstream transmitter only if that transmitter is ready and no earlier transfer is still in flight. Otherwise the frame is dropped and a pulse reports the drop.

Top module: `ccd_frame_capture`

## Requirements
- R1: While reset is held, and just after it is released, adc_req, buf_we, tx_start, frame_dropped, tx_busy and overrun are all 0.
- R2: When armed and idle between pixels, a rising edge of pix_trig produces a one-cycle adc_req with adc_chan=0. The cycle after the matching adc_done, a second one-cycle adc_req follows with adc_chan=1.
- R3: Each conversion result is written one cycle after its adc_done, with buf_we=1. buf_wdata holds the 12-bit sample zero-extended to 16 bits. The channel 0 sample of pixel k goes to address 2k and the channel 1 sample to address 2k+1.
- R4: A frame is 2*PIXELS_PER_CH words. After the last word is written, capture stops, and later pix_trig edges raise no adc_req until the next arm.
- R5: Every frame_strobe pulse advances a counter. Only the DECIM_N-th pulse arms a capture, and it also clears the counter. A trigger edge before arming raises no request.
- R6: An arm that arrives during a partial capture abandons it. The next written word goes to address 0.
- R7: When a frame completes while tx_ready=1 and tx_busy=0, tx_start pulses for one cycle, and from the next cycle tx_busy reads 1.
- R8: tx_busy stays at 1 until a tx_done pulse arrives, and it falls only after one.
- R9: When a frame completes while tx_busy=1 or tx_ready=0, no tx_start is issued and frame_dropped pulses for one cycle.
- R10: A rising edge of pix_trig while either conversion of the current pixel is pending is ignored: it raises no extra adc_req. It sets overrun, which stays at 1 until reset.
- R11: An adc_done that arrives while no conversion is pending writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | Frame-start (shift gate) strobe, one cycle per sensor frame |
| pix_trig | input | 1 | Pixel trigger; its rising edge starts a two-conversion scan |
| adc_req | output | 1 | One-cycle conversion request |
| adc_chan | output | 1 | Channel of the request: 0 = even pixels, 1 = odd pixels |
| adc_done | input | 1 | Conversion finished; adc_data is valid |
| adc_data | input | SAMPLE_W | Conversion result |
| buf_we | output | 1 | Frame buffer write strobe |
| buf_addr | output | ADDR_W | Frame buffer word address |
| buf_wdata | output | WORD_W | Zero-extended sample to store |
| tx_ready | input | 1 | Downstream transmitter can accept a frame |
| tx_start | output | 1 | One-cycle hand-off of a completed frame |
| tx_done | input | 1 | Downstream transfer complete |
| tx_busy | output | 1 | A handed-off frame is still being sent |
| frame_dropped | output | 1 | One-cycle pulse: a completed frame was discarded |
| overrun | output | 1 | Sticky: a trigger came while a conversion was pending |

## Verification
The in-RTL properties watch the cycle-level rules on every cycle:
- an odd-channel request only follows a conversion done, and an even one only follows a trigger edge;
- writes happen only after a done, land inside the frame, and carry address parity that matches the channel;
- a hand-off only happens when downstream was ready and idle, and busy falls only after tx_done;
- a frame either starts a transfer or is dropped, never both, and overrun never clears.

Whole-frame behaviour can only be shown by the bench scenarios. These cover:
- the stored frame matching the samples the converter model returned;
- decimation of the strobes;
- a re-arm that abandons a half-taken frame and restarts at address 0;
- triggers ignored after completion and during a pending conversion;
- frames dropped while downstream is busy or not ready.

// File: rtl/ccd_cap_pkg.sv
package ccd_cap_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_WAIT,
      SEQ_CONV_EVEN,
      SEQ_CONV_ODD
   } seq_state_e;

   localparam logic CHAN_EVEN = 1'b0;
   localparam logic CHAN_ODD  = 1'b1;

endpackage

// File: rtl/ccd_strobe_decim.sv
module ccd_strobe_decim #(
   parameter int DECIM_N = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic arm
);

   generate
      if (DECIM_N < 1) begin : g_bad_n
         $error("ccd_strobe_decim: DECIM_N must be at least 1");
      end

      if (DECIM_N == 1) begin : g_every
         always_ff @(posedge clk) begin
            if (!rst_n) arm <= 1'b0;
            else        arm <= strobe;
         end
      end else begin : g_count
         localparam int CNT_W = $clog2(DECIM_N);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECIM_N - 1);
         logic [CNT_W-1:0] strobe_cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               strobe_cnt <= '0;
               arm        <= 1'b0;
            end else begin
               arm <= 1'b0;
               if (strobe) begin
                  if (strobe_cnt == CNT_LAST) begin
                     strobe_cnt <= '0;
                     arm        <= 1'b1;
                  end else begin
                     strobe_cnt <= strobe_cnt + 1'b1;
                  end
               end
            end
         end
      end
   endgenerate

   AST_ARM_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> $past(strobe)); // R5

endmodule

// File: rtl/ccd_pair_seq.sv
module ccd_pair_seq
   import ccd_cap_pkg::*;
#(
   parameter int SAMPLE_W      = 12,
   parameter int WORD_W        = 16,
   parameter int PIXELS_PER_CH = 3822,
   parameter int ADDR_W        = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic                pix_trig,
   output logic                adc_req,
   output logic                adc_chan,
   input  logic                adc_done,
   input  logic [SAMPLE_W-1:0] adc_data,
   output logic                buf_we,
   output logic [ADDR_W-1:0]   buf_addr,
   output logic [WORD_W-1:0]   buf_wdata,
   output logic                frame_done,
   output logic                overrun
);

   localparam int FRAME_WORDS = 2 * PIXELS_PER_CH;
   localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(FRAME_WORDS - 1);
   localparam int PAD_W = WORD_W - SAMPLE_W;

   seq_state_e        state;
   logic [ADDR_W-1:0] waddr;
   logic              trig_q;
   logic              trig_rise;
   logic [WORD_W-1:0] sample_word;
   logic              pending;

   assign trig_rise = pix_trig & ~trig_q;
   assign pending   = (state == SEQ_CONV_EVEN) || (state == SEQ_CONV_ODD);

   generate
      if (PAD_W < 0) begin : g_bad_w
         $error("ccd_pair_seq: WORD_W must not be narrower than SAMPLE_W");
      end
      if (PAD_W == 0) begin : g_exact
         assign sample_word = adc_data;
      end else begin : g_zext
         assign sample_word = {{PAD_W{1'b0}}, adc_data};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         waddr      <= '0;
         trig_q     <= 1'b0;
         adc_req    <= 1'b0;
         adc_chan   <= CHAN_EVEN;
         buf_we     <= 1'b0;
         buf_addr   <= '0;
         buf_wdata  <= '0;
         frame_done <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         trig_q     <= pix_trig;
         adc_req    <= 1'b0;
         buf_we     <= 1'b0;
         frame_done <= 1'b0;
         if (arm) begin
            state    <= SEQ_WAIT;
            waddr    <= '0;
            adc_chan <= CHAN_EVEN;
         end else begin
            if (pending && trig_rise) overrun <= 1'b1;
            unique case (state)
               SEQ_IDLE: ;
               SEQ_WAIT: begin
                  if (trig_rise) begin
                     state    <= SEQ_CONV_EVEN;
                     adc_req  <= 1'b1;
                     adc_chan <= CHAN_EVEN;
                  end
               end
               SEQ_CONV_EVEN: begin
                  if (adc_done) begin
                     buf_we    <= 1'b1;
                     buf_addr  <= waddr;
                     buf_wdata <= sample_word;
                     waddr     <= waddr + 1'b1;
                     state     <= SEQ_CONV_ODD;
                     adc_req   <= 1'b1;
                     adc_chan  <= CHAN_ODD;
                  end
               end
               SEQ_CONV_ODD: begin
                  if (adc_done) begin
                     buf_we    <= 1'b1;
                     buf_addr  <= waddr;
                     buf_wdata <= sample_word;
                     if (waddr == ADDR_LAST) begin
                        waddr      <= '0;
                        state      <= SEQ_IDLE;
                        frame_done <= 1'b1;
                     end else begin
                        waddr <= waddr + 1'b1;
                        state <= SEQ_WAIT;
                     end
                  end
               end
               default: state <= SEQ_IDLE;
            endcase
         end
      end
   end

   AST_ODD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_req && adc_chan) |-> $past(adc_done)); // R2
   AST_EVEN_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_req && !adc_chan) |-> $past(trig_rise)); // R2
   AST_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> $past(adc_done)); // R11
   AST_ADDR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (buf_addr[0] == $past(adc_chan))); // R3
   AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (buf_addr <= ADDR_LAST)); // R4
   AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (buf_we && buf_addr == ADDR_LAST)); // R4
   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overrun) |-> overrun); // R10

endmodule

// File: rtl/ccd_frame_handoff.sv
module ccd_frame_handoff (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done,
   input  logic tx_ready,
   input  logic tx_done,
   output logic tx_start,
   output logic tx_busy,
   output logic frame_dropped
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_start      <= 1'b0;
         tx_busy       <= 1'b0;
         frame_dropped <= 1'b0;
      end else begin
         tx_start      <= 1'b0;
         frame_dropped <= 1'b0;
         if (tx_done) tx_busy <= 1'b0;
         if (frame_done) begin
            if (tx_ready && !tx_busy) begin
               tx_start <= 1'b1;
               tx_busy  <= 1'b1;
            end else begin
               frame_dropped <= 1'b1;
            end
         end
      end
   end

   AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> ($past(tx_ready) && !$past(tx_busy))); // R7
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> tx_busy); // R7
   AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> $past(tx_done)); // R8
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_start && frame_dropped)); // R9
   AST_FRAME_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_done) |-> (tx_start || frame_dropped)); // R9

endmodule

// File: rtl/ccd_frame_capture.sv
module ccd_frame_capture #(
   parameter int SAMPLE_W      = 12,
   parameter int WORD_W        = 16,
   parameter int PIXELS_PER_CH = 3822,
   parameter int DECIM_N       = 40,
   localparam int ADDR_W       = $clog2(2 * PIXELS_PER_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_strobe,
   input  logic                pix_trig,
   output logic                adc_req,
   output logic                adc_chan,
   input  logic                adc_done,
   input  logic [SAMPLE_W-1:0] adc_data,
   output logic                buf_we,
   output logic [ADDR_W-1:0]   buf_addr,
   output logic [WORD_W-1:0]   buf_wdata,
   input  logic                tx_ready,
   output logic                tx_start,
   input  logic                tx_done,
   output logic                tx_busy,
   output logic                frame_dropped,
   output logic                overrun
);

   generate
      if (PIXELS_PER_CH < 1) begin : g_bad_pix
         $error("ccd_frame_capture: PIXELS_PER_CH must be at least 1");
      end
      if (SAMPLE_W < 1 || WORD_W < SAMPLE_W) begin : g_bad_width
         $error("ccd_frame_capture: need 1 <= SAMPLE_W <= WORD_W");
      end
   endgenerate

   logic arm;
   logic frame_done;

   ccd_strobe_decim #(
      .DECIM_N (DECIM_N)
   ) i_decim (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (frame_strobe),
      .arm    (arm)
   );

   ccd_pair_seq #(
      .SAMPLE_W      (SAMPLE_W),
      .WORD_W        (WORD_W),
      .PIXELS_PER_CH (PIXELS_PER_CH),
      .ADDR_W        (ADDR_W)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .pix_trig   (pix_trig),
      .adc_req    (adc_req),
      .adc_chan   (adc_chan),
      .adc_done   (adc_done),
      .adc_data   (adc_data),
      .buf_we     (buf_we),
      .buf_addr   (buf_addr),
      .buf_wdata  (buf_wdata),
      .frame_done (frame_done),
      .overrun    (overrun)
   );

   ccd_frame_handoff i_handoff (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_done    (frame_done),
      .tx_ready      (tx_ready),
      .tx_done       (tx_done),
      .tx_start      (tx_start),
      .tx_busy       (tx_busy),
      .frame_dropped (frame_dropped)
   );

endmodule

// File: tb/test_ccd_frame_capture.sv
module test_ccd_frame_capture;

   localparam int PIX   = 6;
   localparam int NDEC  = 3;
   localparam int WORDS = 2 * PIX;
   localparam int AW    = $clog2(WORDS);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_strobe = 1'b0;
   logic        pix_trig = 1'b0;
   logic        adc_req, adc_chan;
   logic        adc_done = 1'b0;
   logic [11:0] adc_data = '0;
   logic        buf_we;
   logic [AW-1:0] buf_addr;
   logic [15:0] buf_wdata;
   logic        tx_ready = 1'b1;
   logic        tx_start;
   logic        tx_done = 1'b0;
   logic        tx_busy, frame_dropped, overrun;

   int checks = 0;
   int errors = 0;
   int we_cnt = 0, req_cnt = 0, start_cnt = 0, drop_cnt = 0;
   int first_addr = -1;
   logic [15:0] mem     [WORDS];
   logic [15:0] exp_mem [WORDS];

   always #2.5 clk = ~clk;

   ccd_frame_capture #(
      .SAMPLE_W(12), .WORD_W(16), .PIXELS_PER_CH(PIX), .DECIM_N(NDEC)
   ) i_ccd_frame_capture (
      .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .pix_trig(pix_trig),
      .adc_req(adc_req), .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .tx_ready(tx_ready), .tx_start(tx_start), .tx_done(tx_done),
      .tx_busy(tx_busy), .frame_dropped(frame_dropped), .overrun(overrun)
   );

   function automatic logic [15:0] widen(input logic [11:0] s);
      return {4'b0000, s};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (buf_we) begin
               if (first_addr < 0) first_addr = int'(buf_addr);
               mem[buf_addr] = buf_wdata;
               we_cnt++;
            end
            if (adc_req) req_cnt++;
            if (tx_start) start_cnt++;
            if (frame_dropped) drop_cnt++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic pulse_strobe();
      @(negedge clk) frame_strobe = 1'b1;
      @(negedge clk) frame_strobe = 1'b0;
   endtask

   task automatic arm_capture();
      for (int i = 0; i < NDEC; i++) pulse_strobe();
      repeat (2) @(negedge clk);
      we_cnt = 0;
      first_addr = -1;
      for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
   endtask

   task automatic give_sample(output logic [11:0] s);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      s = 12'($urandom);
      adc_data = s;
      adc_done = 1'b1;
      @(negedge clk) adc_done = 1'b0;
   endtask

   task automatic do_pixel(input int k, input bit poke);
      int n;
      logic [11:0] s0, s1;
      n = 0;
      @(negedge clk) pix_trig = 1'b1;
      do begin @(negedge clk); n++; end while (!adc_req && n < 20);
      check(adc_req && adc_chan == 1'b0, "R2 even request on edge", int'(adc_chan), 0);
      pix_trig = 1'b0;
      if (poke) begin
         @(negedge clk) pix_trig = 1'b1;
         @(negedge clk) pix_trig = 1'b0;
      end
      give_sample(s0);
      check(adc_req && adc_chan == 1'b1, "R2 odd request after done", int'(adc_req), 1);
      give_sample(s1);
      exp_mem[2*k]   = widen(s0);
      exp_mem[2*k+1] = widen(s1);
   endtask

   task automatic run_frame(input int poke_at);
      for (int k = 0; k < PIX; k++) do_pixel(k, k == poke_at);
      repeat (3) @(negedge clk);
      for (int i = 0; i < WORDS; i++)
         check(mem[i] == exp_mem[i], "R3 stored word", int'(mem[i]), int'(exp_mem[i]));
      check(we_cnt == WORDS, "R4 words per frame", we_cnt, WORDS);
   endtask

   initial begin
      int r0, s_cnt;
      void'($urandom(32'd20240611));
      for (int i = 0; i < WORDS; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      repeat (3) @(negedge clk);
      check(!adc_req && !buf_we && !tx_start && !frame_dropped && !tx_busy && !overrun,
            "R1 outputs in reset", int'(adc_req | buf_we | tx_busy | overrun), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!adc_req && !buf_we && !tx_busy && !overrun, "R1 after release",
            int'(adc_req | buf_we | tx_busy | overrun), 0);

      // R5: no capture before the Nth strobe
      r0 = req_cnt;
      @(negedge clk) pix_trig = 1'b1;
      repeat (4) @(negedge clk);
      pix_trig = 1'b0;
      check(req_cnt == r0, "R5 trigger before any strobe", req_cnt, r0);
      for (int i = 0; i < NDEC - 1; i++) pulse_strobe();
      repeat (2) @(negedge clk);
      @(negedge clk) pix_trig = 1'b1;
      repeat (4) @(negedge clk);
      pix_trig = 1'b0;
      check(req_cnt == r0, "R5 trigger after N-1 strobes", req_cnt, r0);
      pulse_strobe();
      repeat (2) @(negedge clk);
      we_cnt = 0; first_addr = -1;

      // R7: first frame with downstream ready
      run_frame(-1);
      check(start_cnt == 1, "R7 tx_start count", start_cnt, 1);
      check(tx_busy == 1'b1, "R7 busy after hand-off", int'(tx_busy), 1);

      // R4: trigger after completion ignored
      r0 = req_cnt;
      @(negedge clk) pix_trig = 1'b1;
      repeat (4) @(negedge clk);
      pix_trig = 1'b0;
      check(req_cnt == r0, "R4 no request after frame end", req_cnt, r0);

      // R9 / R8: frame completes while busy
      arm_capture();
      run_frame(-1);
      check(drop_cnt == 1, "R9 drop while busy", drop_cnt, 1);
      check(start_cnt == 1, "R9 no start while busy", start_cnt, 1);
      check(tx_busy == 1'b1, "R8 busy held without tx_done", int'(tx_busy), 1);
      @(negedge clk) tx_done = 1'b1;
      @(negedge clk) tx_done = 1'b0;
      check(tx_busy == 1'b0, "R8 busy cleared by tx_done", int'(tx_busy), 0);

      // R10 + R9: overrun poke, downstream not ready
      tx_ready = 1'b0;
      check(overrun == 1'b0, "R10 overrun clear before poke", int'(overrun), 0);
      arm_capture();
      r0 = req_cnt;
      run_frame(2);
      check(req_cnt - r0 == WORDS, "R10 extra edge raised no request", req_cnt - r0, WORDS);
      check(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
      check(drop_cnt == 2, "R9 drop when not ready", drop_cnt, 2);
      check(start_cnt == 1, "R9 no start when not ready", start_cnt, 1);
      tx_ready = 1'b1;

      // R11: stray done while waiting
      arm_capture();
      r0 = req_cnt;
      @(negedge clk) begin adc_data = 12'hABC; adc_done = 1'b1; end
      @(negedge clk) adc_done = 1'b0;
      repeat (2) @(negedge clk);
      check(we_cnt == 0, "R11 stray done writes nothing", we_cnt, 0);
      check(req_cnt == r0, "R11 stray done raises no request", req_cnt, r0);

      // R6: re-arm in the middle of a capture
      do_pixel(0, 1'b0);
      do_pixel(1, 1'b0);
      repeat (2) @(negedge clk);
      check(we_cnt == 4, "R6 partial frame written", we_cnt, 4);
      arm_capture();
      run_frame(-1);
      check(first_addr == 0, "R6 restart at address 0", first_addr, 0);
      check(start_cnt == 2, "R7 hand-off after re-arm", start_cnt, 2);
      check(overrun == 1'b1, "R10 overrun still sticky", int'(overrun), 1);

      // R5: a single strobe after a capture does not re-arm
      s_cnt = req_cnt;
      pulse_strobe();
      repeat (2) @(negedge clk);
      @(negedge clk) pix_trig = 1'b1;
      repeat (4) @(negedge clk);
      pix_trig = 1'b0;
      check(req_cnt == s_cnt, "R5 one strobe does not arm", req_cnt, s_cnt);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule